// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block holds three state bits for each of a set of external interrupt lines: an enable bit, a pending bit and an active bit. Requests come from the lines themselves and from software write-one strobes. Handler entry and handler return notifications from the core, each tagged with a line index, move a line between pending and active. The block drives two vectors: one of lines that are both pending and enabled, which goes to a separate priority arbiter, and one of the active lines. The arbiter, the register address decoding and the core's stacking sequence are built elsewhere.

A line is captured when it rises. Any number of rising edges before the core takes the request make only one pending request. When the handler returns and the line is still high, the line is pending again. A fresh rising edge that arrives while the handler is running is captured at once. A level that stays high for the whole handler does not re-pend the line until the return.

Every strobe and notification is sampled on a rising clock edge. The resulting state appears on the outputs one cycle later.

Top module: `irq_state_tracker`

## Requirements
- R1: While reset is held, and on the first cycle after it, all enable, pending, active and ready outputs read zero.
- R2: If a request line is low on one edge and high on the next, the pending bit is set. It stays set after the line falls. A line that stays high creates no new request once its pending bit has been cleared.
- R3: A 1 on bit i of `pend_set_wr` sets pending bit i, and a 1 on bit i of `pend_clr_wr` clears it. Zero bits leave that line's pending bit unchanged.
- R4: A 1 on bit i of `en_set_wr` sets enable bit i, and a 1 on bit i of `en_clr_wr` clears it. If both hit the same bit in the same cycle, the set wins.
- R5: `ready_o` bit i is 1 exactly when pending bit i and enable bit i are both 1. A line that is pending but disabled stays pending.
- R6: If a pending bit is cleared before entry, the request is cancelled: its `ready_o` bit drops and no later request appears.
- R7: An entry notification (`enter_valid` with `enter_idx` = i) sets active bit i and clears pending bit i in the same step. An index at or above the line count has no effect.
- R8: Several pulses on a line before entry make one request: after entry the pending bit stays clear.
- R9: A return notification (`exit_valid` with `exit_idx` = i) clears active bit i. If line i is high on that edge, pending bit i is set in the same step.
- R10: A line held high through the whole handler does not set its pending bit before the return.
- R11: If a line falls and rises again while its handler runs, the pending bit is set while the active bit stays set.
- R12: When a pending-set source (rising edge, set strobe or return with the line high) and a pending-clear source (clear strobe or entry) hit the same bit in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Request lines, one per interrupt |
| en_set_wr | input | NUM_LINES | Write-one strobes that set enable bits |
| en_clr_wr | input | NUM_LINES | Write-one strobes that clear enable bits |
| pend_set_wr | input | NUM_LINES | Write-one strobes that set pending bits |
| pend_clr_wr | input | NUM_LINES | Write-one strobes that clear pending bits |
| enter_valid | input | 1 | Core is entering a handler this cycle |
| enter_idx | input | IDX_W | Line index of the handler being entered |
| exit_valid | input | 1 | Core is returning from a handler this cycle |
| exit_idx | input | IDX_W | Line index of the handler returning |
| enabled_o | output | NUM_LINES | Enable bits |
| pending_o | output | NUM_LINES | Pending bits |
| active_o | output | NUM_LINES | Active bits |
| ready_o | output | NUM_LINES | Pending and enabled, sent to the arbiter |

## Verification
A wrong pending bit shows up one cycle after the edge that caused it, on both `pending_o` and `ready_o`. A lost request leaves a line that the arbiter never sees. A stale request makes the handler run twice, which shows as an entry followed by a pending bit that comes back without any new rising edge. A wrong active bit shows on `active_o` one cycle after the entry or return notification. A wrong priority between a set source and a clear source appears only in the cycle where both land, so every collision case is driven on purpose and sampled on the very next cycle.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

   // Input conditioning applied to each request line before edge detection.
   typedef enum logic [0:0] {
      LINE_DIRECT   = 1'b0,
      LINE_TWO_FLOP = 1'b1
   } line_sync_e;

   // Index width for a given line count, never below one bit.
   function automatic int idx_width(input int lines);
      return (lines <= 2) ? 1 : $clog2(lines);
   endfunction

endpackage

// File: rtl/irq_index_decode.sv
module irq_index_decode #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
) (
   input  logic                 valid,
   input  logic [IDX_W-1:0]     idx,
   output logic [NUM_LINES-1:0] hit
);

   // One comparator per line; an index at or above NUM_LINES matches no line.
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
      assign hit[i] = valid && (idx == IDX_W'(i));
   end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
   import irq_trk_pkg::*;
#(
   parameter line_sync_e SYNC_MODE = LINE_DIRECT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic en_set,
   input  logic en_clr,
   input  logic pend_set,
   input  logic pend_clr,
   input  logic enter_hit,
   input  logic exit_hit,
   output logic en_q,
   output logic pend_q,
   output logic act_q
);

   logic line_s;
   logic line_prev_q;

   if (SYNC_MODE == LINE_TWO_FLOP) begin : g_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[0], line_in};
      end
      assign line_s = sync_q[1];
   end else begin : g_direct
      assign line_s = line_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) line_prev_q <= 1'b0;
      else        line_prev_q <= line_s;
   end

   logic rise;
   logic pend_up;
   logic pend_down;

   assign rise      = line_s & ~line_prev_q;
   // Set sources outrank clear sources so that a new request is never lost.
   assign pend_up   = rise | pend_set | (exit_hit & line_s);
   assign pend_down = pend_clr | enter_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         en_q   <= en_set | (en_q & ~en_clr);
         pend_q <= pend_up | (pend_q & ~pend_down);
         act_q  <= enter_hit | (act_q & ~exit_hit);
      end
   end

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
   import irq_trk_pkg::*;
#(
   parameter int         NUM_LINES = 8,
   parameter line_sync_e SYNC_MODE = LINE_DIRECT,
   parameter int         IDX_W     = idx_width(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [NUM_LINES-1:0] en_set_wr,
   input  logic [NUM_LINES-1:0] en_clr_wr,
   input  logic [NUM_LINES-1:0] pend_set_wr,
   input  logic [NUM_LINES-1:0] pend_clr_wr,
   input  logic                 enter_valid,
   input  logic [IDX_W-1:0]     enter_idx,
   input  logic                 exit_valid,
   input  logic [IDX_W-1:0]     exit_idx,
   output logic [NUM_LINES-1:0] enabled_o,
   output logic [NUM_LINES-1:0] pending_o,
   output logic [NUM_LINES-1:0] active_o,
   output logic [NUM_LINES-1:0] ready_o
);

   if (NUM_LINES < 1 || NUM_LINES > 1024) begin : g_bad_lines
      $error("irq_state_tracker: NUM_LINES out of range");
   end
   if ((1 << IDX_W) < NUM_LINES) begin : g_bad_idx
      $error("irq_state_tracker: IDX_W too narrow for NUM_LINES");
   end

   logic [NUM_LINES-1:0] enter_hit;
   logic [NUM_LINES-1:0] exit_hit;

   irq_index_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_enter_dec (
      .valid (enter_valid),
      .idx   (enter_idx),
      .hit   (enter_hit)
   );

   irq_index_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_exit_dec (
      .valid (exit_valid),
      .idx   (exit_idx),
      .hit   (exit_hit)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      irq_line_cell #(.SYNC_MODE(SYNC_MODE)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_in   (irq_lines[i]),
         .en_set    (en_set_wr[i]),
         .en_clr    (en_clr_wr[i]),
         .pend_set  (pend_set_wr[i]),
         .pend_clr  (pend_clr_wr[i]),
         .enter_hit (enter_hit[i]),
         .exit_hit  (exit_hit[i]),
         .en_q      (enabled_o[i]),
         .pend_q    (pending_o[i]),
         .act_q     (active_o[i])
      );
   end

   assign ready_o = pending_o & enabled_o;

endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk
   import irq_trk_pkg::*;
#(
   parameter int         NUM_LINES = 8,
   parameter line_sync_e SYNC_MODE = LINE_DIRECT,
   parameter int         IDX_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic [NUM_LINES-1:0] en_set_wr,
   input logic [NUM_LINES-1:0] en_clr_wr,
   input logic [NUM_LINES-1:0] pend_set_wr,
   input logic [NUM_LINES-1:0] pend_clr_wr,
   input logic                 enter_valid,
   input logic [IDX_W-1:0]     enter_idx,
   input logic                 exit_valid,
   input logic [IDX_W-1:0]     exit_idx,
   input logic [NUM_LINES-1:0] enabled_o,
   input logic [NUM_LINES-1:0] pending_o,
   input logic [NUM_LINES-1:0] active_o,
   input logic [NUM_LINES-1:0] ready_o
);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
      assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
         en_set_wr[i] |=> enabled_o[i]);
      assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (en_clr_wr[i] && !en_set_wr[i]) |=> !enabled_o[i]);
      assert_pend_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
         pend_set_wr[i] |=> pending_o[i]);
      assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ready_o[i] |-> (pending_o[i] && enabled_o[i]));
      assert_enter_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (enter_valid && enter_idx == IDX_W'(i)) |=> active_o[i]);
      assert_exit_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (exit_valid && exit_idx == IDX_W'(i) &&
          !(enter_valid && enter_idx == IDX_W'(i))) |=> !active_o[i]);
      assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_set_wr[i] && (pend_clr_wr[i] ||
          (enter_valid && enter_idx == IDX_W'(i)))) |=> pending_o[i]);

      if (SYNC_MODE == LINE_DIRECT) begin : g_direct_chk
         assert_enter_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (enter_valid && enter_idx == IDX_W'(i) && !pend_set_wr[i] && !irq_lines[i])
            |=> !pending_o[i]);
         assert_exit_repend_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (exit_valid && exit_idx == IDX_W'(i) && irq_lines[i]) |=> pending_o[i]);
         assert_pend_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_clr_wr[i] && !pend_set_wr[i] && !irq_lines[i]) |=> !pending_o[i]);
         assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_set_wr[i] && !pend_clr_wr[i] && !irq_lines[i] &&
             !(enter_valid && enter_idx == IDX_W'(i)))
            |=> (pending_o[i] == $past(pending_o[i])));
      end
   end

endmodule

bind irq_state_tracker irq_state_tracker_chk #(
   .NUM_LINES (NUM_LINES),
   .SYNC_MODE (SYNC_MODE),
   .IDX_W     (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_lines   (irq_lines),
   .en_set_wr   (en_set_wr),
   .en_clr_wr   (en_clr_wr),
   .pend_set_wr (pend_set_wr),
   .pend_clr_wr (pend_clr_wr),
   .enter_valid (enter_valid),
   .enter_idx   (enter_idx),
   .exit_valid  (exit_valid),
   .exit_idx    (exit_idx),
   .enabled_o   (enabled_o),
   .pending_o   (pending_o),
   .active_o    (active_o),
   .ready_o     (ready_o)
);

// File: tb/irq_state_tracker_test.sv
module irq_state_tracker_test;
   import irq_trk_pkg::*;

   localparam int N  = 6;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_lines = '0;
   logic [N-1:0]  en_set_wr = '0;
   logic [N-1:0]  en_clr_wr = '0;
   logic [N-1:0]  pend_set_wr = '0;
   logic [N-1:0]  pend_clr_wr = '0;
   logic          enter_valid = 1'b0;
   logic [IW-1:0] enter_idx = '0;
   logic          exit_valid = 1'b0;
   logic [IW-1:0] exit_idx = '0;
   logic [N-1:0]  enabled_o, pending_o, active_o, ready_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   irq_state_tracker #(.NUM_LINES(N), .SYNC_MODE(LINE_DIRECT), .IDX_W(IW)) uut (
      .clk, .rst_n, .irq_lines, .en_set_wr, .en_clr_wr, .pend_set_wr, .pend_clr_wr,
      .enter_valid, .enter_idx, .exit_valid, .exit_idx,
      .enabled_o, .pending_o, .active_o, .ready_o
   );

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Advance to the next falling edge, passing one rising edge.
   task automatic step(input int n = 1);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic strobe_clear();
      en_set_wr = '0; en_clr_wr = '0; pend_set_wr = '0; pend_clr_wr = '0;
      enter_valid = 1'b0; exit_valid = 1'b0;
   endtask

   task automatic t_reset();
      step(3);
      check("R1 enabled", enabled_o, '0);
      check("R1 pending", pending_o, '0);
      check("R1 active", active_o, '0);
      rst_n = 1'b1;
      step();
      check("R1 ready after release", ready_o, '0);
   endtask

   task automatic t_edge();
      irq_lines[0] = 1'b1; step();
      check("R2 rise sets pending", pending_o, 6'b000001);
      irq_lines[0] = 1'b0; step();
      check("R2 pending kept after fall", pending_o, 6'b000001);
      pend_clr_wr = 6'b000001; step(); strobe_clear();
      irq_lines[1] = 1'b1; step();
      check("R2 line1 rise", pending_o, 6'b000010);
      pend_clr_wr = 6'b000010; step(); strobe_clear();
      step(2);
      check("R2 held level no new request", pending_o, 6'b000000);
      irq_lines[1] = 1'b0; step();
   endtask

   task automatic t_sw();
      pend_set_wr = 6'b000100; step(); strobe_clear();
      check("R3 set strobe", pending_o, 6'b000100);
      step();
      check("R3 zero strobes no effect", pending_o, 6'b000100);
      pend_set_wr = 6'b000100; pend_clr_wr = 6'b000100; step(); strobe_clear();
      check("R12 set beats clear strobe", pending_o, 6'b000100);
      pend_clr_wr = 6'b000100; step(); strobe_clear();
      check("R3 clear strobe", pending_o, 6'b000000);
   endtask

   task automatic t_enable();
      en_set_wr = 6'b001001; step(); strobe_clear();
      check("R4 enable set", enabled_o, 6'b001001);
      pend_set_wr = 6'b000011; step(); strobe_clear();
      check("R5 ready", ready_o, 6'b000001);
      check("R5 disabled stays pending", pending_o, 6'b000011);
      en_set_wr = 6'b000001; en_clr_wr = 6'b000001; step(); strobe_clear();
      check("R4 set beats clear", enabled_o, 6'b001001);
      en_clr_wr = 6'b001000; step(); strobe_clear();
      check("R4 enable clear", enabled_o, 6'b000001);
      pend_clr_wr = 6'b000001; step(); strobe_clear();
      check("R6 cancel drops ready", ready_o, 6'b000000);
      step(2);
      check("R6 no later request", pending_o, 6'b000010);
      pend_clr_wr = 6'b000010; step(); strobe_clear();
   endtask

   task automatic t_entry();
      for (int p = 0; p < 3; p++) begin
         irq_lines[3] = 1'b1; step();
         irq_lines[3] = 1'b0; step();
      end
      check("R8 pulses pending", pending_o, 6'b001000);
      enter_valid = 1'b1; enter_idx = 3'd3; step(); strobe_clear();
      check("R7 entry active", active_o, 6'b001000);
      check("R7 entry clears pending", pending_o, 6'b000000);
      step(2);
      check("R8 single request", pending_o, 6'b000000);
      exit_valid = 1'b1; exit_idx = 3'd3; step(); strobe_clear();
      check("R9 return clears active", active_o, 6'b000000);
      check("R9 low line no re-pend", pending_o, 6'b000000);
      pend_set_wr = 6'b000001; step(); strobe_clear();
      enter_valid = 1'b1; enter_idx = 3'd7; step(); strobe_clear();
      check("R7 out-of-range active", active_o, 6'b000000);
      check("R7 out-of-range pending", pending_o, 6'b000001);
      pend_clr_wr = 6'b000001; step(); strobe_clear();
   endtask

   task automatic t_hold();
      irq_lines[4] = 1'b1; step();
      enter_valid = 1'b1; enter_idx = 3'd4; step(); strobe_clear();
      check("R7 entry line4", active_o, 6'b010000);
      step(3);
      check("R10 held level no re-pend", pending_o, 6'b000000);
      exit_valid = 1'b1; exit_idx = 3'd4; step(); strobe_clear();
      check("R9 return with line high active", active_o, 6'b000000);
      check("R9 return with line high re-pends", pending_o, 6'b010000);
      irq_lines[4] = 1'b0;
      pend_clr_wr = 6'b010000; step(); strobe_clear();
   endtask

   task automatic t_repulse();
      irq_lines[5] = 1'b1; step();
      enter_valid = 1'b1; enter_idx = 3'd5; step(); strobe_clear();
      irq_lines[5] = 1'b0; step();
      check("R11 no pend after fall", pending_o, 6'b000000);
      irq_lines[5] = 1'b1; step();
      check("R11 repulse pends", pending_o, 6'b100000);
      check("R11 still active", active_o, 6'b100000);
      exit_valid = 1'b1; exit_idx = 3'd5; step(); strobe_clear();
      irq_lines[5] = 1'b0;
      pend_clr_wr = 6'b100000; step(); strobe_clear();
   endtask

   task automatic t_race();
      pend_set_wr = 6'b000001; enter_valid = 1'b1; enter_idx = 3'd0; step(); strobe_clear();
      check("R12 set beats entry pending", pending_o, 6'b000001);
      check("R12 entry still active", active_o, 6'b000001);
      exit_valid = 1'b1; exit_idx = 3'd0; step(); strobe_clear();
      check("R9 exit line0", active_o, 6'b000000);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_edge();
      t_sw();
      t_enable();
      t_entry();
      t_hold();
      t_repulse();
      t_race();
      finish_run();
   end

   initial begin
      #(20 * 20000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

endmodule